// File: doc/BRIEF.md
# Program ROM Bank Mapper

This block sits between an 8-bit CPU bus and a cartridge's program memory. It watches CPU writes in the upper register area and stores three 6-bit bank numbers. Each number picks the 8 KB slice of program ROM that appears in one of three switchable CPU windows. The topmost 8 KB CPU window is wired to the final ROM bank, so reset and interrupt vectors are always reachable.

The same register that sets the second window also holds two flags in its top data bits. Each flag tells the pattern mapper to treat its high page numbers as ROM rather than RAM: one flag serves the lower pattern half and the other the upper half. The block exports both flags. It also decodes the 8 KB work RAM area and asserts a ROM select for the whole upper half of the CPU space.

Address translation is purely combinational from the CPU address and the stored bank numbers. Register loads happen on the rising clock edge on which a qualified write is presented.

Top module: `prg_bank_mapper`

## Requirements
- R1: While reset is active, and after it is released, all three bank numbers and both CHR-RAM disable flags read as zero until the first qualified write.
- R2: A CPU address in $8000-$9FFF gives prg_addr = {bank0, cpu_addr[12:0]}, where bank0 is loaded through the register at $E000-$E7FF.
- R3: $A000-$BFFF maps through bank1 (register $E800-$EFFF), and $C000-$DFFF maps through bank2 (register $F000-$F7FF), both in the form {bank, cpu_addr[12:0]}.
- R4: $E000-$FFFF always gives prg_addr = {6'h3F, cpu_addr[12:0]}, whatever the registers hold.
- R5: A qualified write loads cpu_data[5:0] into the bank register chosen by cpu_addr[15:11] (11100, 11101 or 11110). cpu_addr[10:0] are ignored, so every address in a $800 range reaches the same register.
- R6: A qualified write to $E800-$EFFF sets chr_ram_off_lo from cpu_data[6] and chr_ram_off_hi from cpu_data[7]. Writes to the other two bank registers leave both flags unchanged.
- R7: Nothing changes unless cpu_strobe is 1 and cpu_rw is 0 (write) on a rising clock edge. Reads, cycles with the strobe low, and writes to $F800-$FFFF, to $6000-$7FFF or to any address below $E000 leave the banks and flags unchanged.
- R8: prg_rom_sel equals cpu_addr[15]. wram_sel is 1 exactly for $6000-$7FFF. The two selects are never 1 together.
- R9: When prg_rom_sel is 0, prg_addr is zero.
- R10: A write sampled on one rising edge is visible on prg_addr and on the flags immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-synchronous clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_strobe | input | 1 | Bus cycle valid, sampled on the rising edge |
| prg_addr | output | 19 | Program ROM byte address |
| prg_rom_sel | output | 1 | Program ROM chip select |
| wram_sel | output | 1 | Work RAM select |
| chr_ram_off_lo | output | 1 | CHR-RAM disable for the lower pattern half |
| chr_ram_off_hi | output | 1 | CHR-RAM disable for the upper pattern half |

## Verification
The assertions check on every cycle that:
- the fixed top window always reads the last bank;
- the ROM and work RAM selects never overlap;
- prg_addr is zero outside ROM space;
- at most one register load fires per cycle;
- bank numbers and flags hold steady on any cycle without a matching load.

Only the bench scenarios can show:
- the data actually lands in the register chosen by aliased addresses;
- the flag bits are taken only from the $E800 range;
- reads and strobe-less cycles have no effect;
- each window translates through its own bank.

The bench shows these with directed corner cases and seeded random bus traffic, compared against a reference model.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  // CPU window index, taken from cpu_addr[14:13] in ROM space
  typedef enum logic [1:0] {
    WIN_LOW   = 2'd0,
    WIN_MID   = 2'd1,
    WIN_HIGH  = 2'd2,
    WIN_FIXED = 2'd3
  } win_e;

  localparam int NUM_SW_WIN = 3;
  localparam int FLAG_WIN   = 1;  // register that also carries the flags
  localparam logic [4:0] REG_BASE_TAG = 5'b11100;  // cpu_addr[15:11] of first bank register
endpackage

// File: rtl/prg_reg_decode.sv
module prg_reg_decode
  import prg_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_WIN = NUM_SW_WIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_strobe,
  output logic [NUM_WIN-1:0] load
);
  localparam int TAG_W = 5;
  logic wr_qual;
  assign wr_qual = cpu_strobe && !cpu_rw;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_dec
    assign load[i] = wr_qual &&
                     (cpu_addr[ADDR_W-1 -: TAG_W] == TAG_W'(REG_BASE_TAG + TAG_W'(i)));
  end

  // R5: one register per $800 range, never two at once
  a_r5_one_load: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(load));
  // R7: reads never load
  a_r7_read_no_load: assert property (@(posedge clk) disable iff (!rst_n) cpu_rw |-> (load == '0));
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_map_pkg::*;
#(
  parameter int BANK_W  = 6,
  parameter int DATA_W  = 8,
  parameter int NUM_WIN = NUM_SW_WIN
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_WIN-1:0]             load,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_WIN-1:0][BANK_W-1:0] bank_q,
  output logic                           flag_lo,
  output logic                           flag_hi
);
  localparam int LO_BIT = DATA_W - 2;
  localparam int HI_BIT = DATA_W - 1;

  logic [NUM_WIN-1:0][BANK_W-1:0] bank_d;
  logic flag_lo_d, flag_hi_d;
  logic flag_en;

  assign flag_en = load[FLAG_WIN];

  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) begin
      bank_d[i] = load[i] ? wdata[BANK_W-1:0] : bank_q[i];
    end
    flag_lo_d = flag_en ? wdata[LO_BIT] : flag_lo;
    flag_hi_d = flag_en ? wdata[HI_BIT] : flag_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
    end else begin
      if (|load) bank_q <= bank_d;
      if (flag_en) begin
        flag_lo <= flag_lo_d;
        flag_hi <= flag_hi_d;
      end
    end
  end

  // R7: banks hold when no load fires
  a_r7_banks_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load == '0) |=> $stable(bank_q));
  // R6: flags move only through the flag-carrying register
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load[FLAG_WIN] |=> ($stable(flag_lo) && $stable(flag_hi)));
  // R10: a load is visible right after its edge
  a_r10_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    load[0] |=> (bank_q[0] == $past(wdata[BANK_W-1:0])));
endmodule

// File: rtl/prg_addr_xlate.sv
module prg_addr_xlate
  import prg_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 6,
  parameter int NUM_WIN = NUM_SW_WIN,
  localparam int PAGE_W = ADDR_W - 3,
  localparam int OUT_W  = BANK_W + PAGE_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              cpu_addr,
  input  logic [NUM_WIN-1:0][BANK_W-1:0] bank_q,
  output logic [OUT_W-1:0]               prg_addr,
  output logic                           rom_sel,
  output logic                           wram_sel
);
  localparam logic [BANK_W-1:0] LAST_BANK = '1;

  win_e              win;
  logic [BANK_W-1:0] bank;

  always_comb begin
    win = win_e'(cpu_addr[PAGE_W+1:PAGE_W]);
    case (win)
      WIN_LOW:  bank = bank_q[0];
      WIN_MID:  bank = bank_q[1];
      WIN_HIGH: bank = bank_q[2];
      default:  bank = LAST_BANK;
    endcase
    rom_sel  = cpu_addr[ADDR_W-1];
    wram_sel = (cpu_addr[ADDR_W-1:PAGE_W] == 3'b011);
    prg_addr = rom_sel ? {bank, cpu_addr[PAGE_W-1:0]} : '0;
  end

  // R4: top window is always the last bank
  a_r4_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:PAGE_W] == 3'b111) |-> (prg_addr[OUT_W-1:PAGE_W] == LAST_BANK));
  // R8: selects never overlap
  a_r8_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && wram_sel));
  // R9: no address driven outside ROM space
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_sel |-> (prg_addr == '0));
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 6,
  localparam int OUT_W = BANK_W + ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              cpu_strobe,
  output logic [OUT_W-1:0]  prg_addr,
  output logic              prg_rom_sel,
  output logic              wram_sel,
  output logic              chr_ram_off_lo,
  output logic              chr_ram_off_hi
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [NUM_SW_WIN-1:0]             load;
  logic [NUM_SW_WIN-1:0][BANK_W-1:0] bank_q;

  prg_reg_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_SW_WIN)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .cpu_addr(cpu_addr),
    .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .load(load)
  );

  prg_bank_regs #(.BANK_W(BANK_W), .DATA_W(DATA_W), .NUM_WIN(NUM_SW_WIN)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .load(load), .wdata(cpu_data),
    .bank_q(bank_q), .flag_lo(chr_ram_off_lo), .flag_hi(chr_ram_off_hi)
  );

  prg_addr_xlate #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_WIN(NUM_SW_WIN)) u_xlate (
    .clk(clk), .rst_n(rst_int_n), .cpu_addr(cpu_addr), .bank_q(bank_q),
    .prg_addr(prg_addr), .rom_sel(prg_rom_sel), .wram_sel(wram_sel)
  );
endmodule

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_rw;
  logic        cpu_strobe;
  logic [18:0] prg_addr;
  logic        prg_rom_sel, wram_sel, chr_ram_off_lo, chr_ram_off_hi;

  always #2.5 clk = ~clk;

  prg_bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .prg_addr(prg_addr),
    .prg_rom_sel(prg_rom_sel), .wram_sel(wram_sel),
    .chr_ram_off_lo(chr_ram_off_lo), .chr_ram_off_hi(chr_ram_off_hi)
  );

  int   n_vec = 0;
  int   n_bad = 0;
  logic [5:0] m_bank [3];
  logic       m_lo, m_hi;

  function automatic logic [18:0] exp_addr(input logic [15:0] a);
    logic [5:0] b;
    if (!a[15]) return 19'd0;                       // R9
    case (a[14:13])
      2'd0: b = m_bank[0];                          // R2
      2'd1: b = m_bank[1];                          // R3
      2'd2: b = m_bank[2];                          // R3
      default: b = 6'h3F;                           // R4
    endcase
    return {b, a[12:0]};
  endfunction

  function automatic logic exp_wram(input logic [15:0] a);
    return a[15:13] == 3'b011;                       // R8
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw, input logic st);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_strobe = st;
    @(posedge clk);
    if (st && !rw && a[15:11] >= 5'b11100 && a[15:11] <= 5'b11110) begin   // R5 R7
      m_bank[a[12:11]] = d[5:0];
      if (a[15:11] == 5'b11101) begin m_lo = d[6]; m_hi = d[7]; end        // R6
    end
    #1 cpu_strobe = 1'b0;
  endtask

  task automatic probe(input string req, input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_strobe = 1'b0;
    #1;
    chk(req, 32'(prg_addr), 32'(exp_addr(a)));
    chk("R8", {30'd0, prg_rom_sel, wram_sel}, {30'd0, a[15], exp_wram(a)});
    chk(req, {30'd0, chr_ram_off_hi, chr_ram_off_lo}, {30'd0, m_hi, m_lo});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++; n_vec++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24681));
    m_bank[0] = '0; m_bank[1] = '0; m_bank[2] = '0; m_lo = 0; m_hi = 0;
    cpu_addr = 16'h0000; cpu_data = '0; cpu_rw = 1'b1; cpu_strobe = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 chk("R1", {30'd0, chr_ram_off_hi, chr_ram_off_lo}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1 reset state through each window
    probe("R1", 16'h8123); probe("R1", 16'hA456); probe("R1", 16'hC789);
    probe("R4", 16'hFFFC);
    // R5/R6: bits 7:6 of $E000 write do not reach flags
    bus(16'hE000, 8'hC5, 1'b0, 1'b1);
    probe("R6", 16'h9FFF);
    // R5 aliasing at the top of the $E800 range, R6 flags, R10 next cycle
    bus(16'hEFFF, 8'hAA, 1'b0, 1'b1);
    probe("R10", 16'hA001);
    bus(16'hF7FF, 8'h51, 1'b0, 1'b1);
    probe("R3", 16'hDABC);
    // R7: read, strobe low, out-of-range writes
    bus(16'hE000, 8'h3F, 1'b1, 1'b1);
    bus(16'hE800, 8'h7F, 1'b0, 1'b0);
    bus(16'hF800, 8'hFF, 1'b0, 1'b1);
    bus(16'h6000, 8'hFF, 1'b0, 1'b1);
    bus(16'hC000, 8'hFF, 1'b0, 1'b1);
    probe("R7", 16'h8000); probe("R7", 16'hA000); probe("R7", 16'hC000);
    // R4 fixed window regardless of banks
    probe("R4", 16'hE000);
    // R8/R9 work RAM and low space
    probe("R8", 16'h6000); probe("R8", 16'h7FFF); probe("R9", 16'h5FFF);
    probe("R9", 16'h0000);
    bus(16'hE800, 8'h40, 1'b0, 1'b1);
    probe("R6", 16'hBFFF);
    // seeded random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [1:0] pick;
      pick = 2'($urandom);
      a = 16'($urandom);
      if (pick != 0) a[15:13] = 3'b111;
      bus(a, 8'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 != 0));
      probe("R2", 16'($urandom));
    end
    finish_run();
  end
endmodule